// File: doc/BRIEF.md
# Cross-Bus Wait-State Transfer Synchronizer

This block sits between an expansion-slot bus of a personal computer and an 8-bit host bus whose processor has been tristated for a DMA transfer. When the computer issues a memory cycle into a fixed address window, the block pulls the slot's ready line low in the same cycle. The computer stays stalled until the host bus offers a valid cycle. A host cycle is valid while the host clock is in its high phase and the host's bus-available line is high.

During the valid phase, the block opens the buffer that drives the computer's write data onto the host bus. When the valid phase ends, the block releases the computer. A recovery counter then waits two host clock cycles before the logic can stall the computer again. The host clock and bus-available inputs are asynchronous and pass through synchronizers. All logic runs on one fast sampling clock.

Top module: `xfer_wait_sync`

## Requirements
- R1: While reset is held, and in the cycles after it with no access, `pc_rdy` is 1 and `buf_en` is 0.
- R2: When `pc_req` is 1 and `pc_addr` lies between `WIN_BASE` and `WIN_LAST` inclusive (defaults 0x0D000 and 0x0DFFF), `pc_rdy` goes to 0 in the same cycle, with no clock edge in between, unless a release is pending.
- R3: A request whose address is outside the window never lowers `pc_rdy` and never raises `buf_en`.
- R4: The valid signal is the AND of `host_phi` and `host_ba`, each delayed by `SYNC_STAGES` sampling clocks. The transfer is armed at the clock edge where a window request and the valid signal first coincide.
- R5: `buf_en` is 1 exactly when the transfer is armed, the valid signal is 1, `pc_wr_n` is 0 (active-low write) and `xfer_grant` is 1. A read (`pc_wr_n`=1), or a write without the grant, never raises it.
- R6: `pc_rdy` stays 0 from the window request until release, even through several host clock periods in which `host_ba` is 0.
- R7: When the valid signal falls while the transfer is armed, a release is recorded at that clock edge, and `pc_rdy` is 1 from that point on.
- R8: During a release, a counter counts rising edges of the synchronized host clock. At the edge after it reaches `RECOV_COUNT` (default 2), the arm is cleared. The release clears one edge later. After that, a new window request stalls the computer again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_req | input | 1 | Computer memory cycle in progress |
| pc_addr | input | ADDR_W | Computer memory address |
| pc_wr_n | input | 1 | Computer memory write strobe, active low |
| host_phi | input | 1 | Host bus clock, asynchronous |
| host_ba | input | 1 | Host bus-available, asynchronous |
| xfer_grant | input | 1 | Host bus taken over for DMA |
| pc_rdy | output | 1 | Slot ready line; 0 stalls the computer |
| buf_en | output | 1 | Write data buffer enable toward the host bus, active high |

## Verification
The hardest state to reach from the ports is a stall that begins while the host bus is unavailable. The request and the host's valid phase then meet only several host periods later, and the release must follow the next fall of the valid phase rather than the earlier phase edges. The stimulus holds `host_ba` low while the host clock keeps toggling, asserts a window write, and only then raises `host_ba`. A behavioural model compares `pc_rdy` and `buf_en` on every sampling clock through stall, buffer enable, release and the two-cycle recovery.

// File: rtl/xs_pkg.sv
package xs_pkg;

  typedef struct packed {
    logic valid;
    logic valid_fall;
    logic host_rise;
  } xs_phase_t;

endpackage

// File: rtl/xs_sync.sv
module xs_sync #(
  parameter int STAGES = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      assign chain_d = d;
    end else begin : g_many
      assign chain_d = {chain_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/xs_win_decode.sv
module xs_win_decode #(
  parameter int ADDR_W = 20,
  parameter logic [ADDR_W-1:0] WIN_BASE = 20'h0D000,
  parameter logic [ADDR_W-1:0] WIN_LAST = 20'h0DFFF
) (
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  logic above_base;
  logic below_last;

  always_comb begin
    above_base = (addr >= WIN_BASE);
    below_last = (addr <= WIN_LAST);
    hit        = req & above_base & below_last;
  end
endmodule

// File: rtl/xs_phase.sv
module xs_phase
  import xs_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      phi_s,
  input  logic      ba_s,
  output xs_phase_t ph
);
  logic phi_q, phi_d;
  logic valid_q, valid_d;

  always_comb begin
    valid_d       = phi_s & ba_s;
    phi_d         = phi_s;
    ph.valid      = valid_d;
    ph.valid_fall = valid_q & ~valid_d;
    ph.host_rise  = phi_s & ~phi_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phi_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      phi_q   <= phi_d;
      valid_q <= valid_d;
    end
  end
endmodule

// File: rtl/xs_ctrl.sv
module xs_ctrl
  import xs_pkg::*;
#(
  parameter int RECOV_COUNT = 2,
  localparam int CNT_W = $clog2(RECOV_COUNT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  xs_phase_t        ph,
  output logic             arm_q,
  output logic             rel_q,
  output logic [CNT_W-1:0] cnt_q
);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RECOV_COUNT);

  logic             coin_q, coin_d;
  logic             arm_d, rel_d;
  logic [CNT_W-1:0] cnt_d;
  logic             arm_set, arm_clr, cnt_en;

  always_comb begin
    coin_d  = hit & ph.valid;
    arm_set = coin_d & ~coin_q & ~rel_q;
    arm_clr = arm_q & (cnt_q == CNT_LAST);
    cnt_en  = rel_q & ph.host_rise & (cnt_q != CNT_LAST);

    arm_d = arm_q;
    if (arm_clr)      arm_d = 1'b0;
    else if (arm_set) arm_d = 1'b1;

    rel_d = rel_q;
    if (!arm_q)             rel_d = 1'b0;
    else if (ph.valid_fall) rel_d = 1'b1;

    cnt_d = cnt_q;
    if (!rel_q)      cnt_d = '0;
    else if (cnt_en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coin_q <= 1'b0;
      arm_q  <= 1'b0;
      rel_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      coin_q <= coin_d;
      arm_q  <= arm_d;
      rel_q  <= rel_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/xfer_wait_sync.sv
module xfer_wait_sync
  import xs_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter logic [ADDR_W-1:0] WIN_BASE = 20'h0D000,
  parameter logic [ADDR_W-1:0] WIN_LAST = 20'h0DFFF,
  parameter int SYNC_STAGES = 2,
  parameter int RECOV_COUNT = 2,
  localparam int CNT_W = $clog2(RECOV_COUNT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pc_req,
  input  logic [ADDR_W-1:0] pc_addr,
  input  logic              pc_wr_n,
  input  logic              host_phi,
  input  logic              host_ba,
  input  logic              xfer_grant,
  output logic              pc_rdy,
  output logic              buf_en
);
  logic             rst_n_i;
  logic             phi_s, ba_s, hit;
  xs_phase_t        ph;
  logic             arm, rel;
  logic [CNT_W-1:0] rcnt;

  // reset asserts at once, deasserts on a clock edge
  xs_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rst (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_n_i));

  xs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_phi (
    .clk(clk), .rst_n(rst_n_i), .d(host_phi), .q(phi_s));

  xs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ba (
    .clk(clk), .rst_n(rst_n_i), .d(host_ba), .q(ba_s));

  xs_win_decode #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_LAST(WIN_LAST)) u_dec (
    .req(pc_req), .addr(pc_addr), .hit(hit));

  xs_phase u_phase (
    .clk(clk), .rst_n(rst_n_i), .phi_s(phi_s), .ba_s(ba_s), .ph(ph));

  xs_ctrl #(.RECOV_COUNT(RECOV_COUNT)) u_ctrl (
    .clk(clk), .rst_n(rst_n_i), .hit(hit), .ph(ph),
    .arm_q(arm), .rel_q(rel), .cnt_q(rcnt));

  always_comb begin
    pc_rdy = ~(hit & ~rel);
    buf_en = arm & ph.valid & ~pc_wr_n & xfer_grant;
  end
endmodule

// File: rtl/xs_checker.sv
module xs_checker #(
  parameter int ADDR_W = 20,
  parameter logic [ADDR_W-1:0] WIN_BASE = 20'h0D000,
  parameter logic [ADDR_W-1:0] WIN_LAST = 20'h0DFFF,
  parameter int RECOV_COUNT = 2,
  localparam int CNT_W = $clog2(RECOV_COUNT + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pc_req,
  input logic [ADDR_W-1:0] pc_addr,
  input logic              pc_wr_n,
  input logic              xfer_grant,
  input logic              pc_rdy,
  input logic              buf_en,
  input logic              arm,
  input logic              rel,
  input logic [CNT_W-1:0]  rcnt
);
  a_r3_stall_needs_window: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_rdy |-> (pc_req && pc_addr >= WIN_BASE && pc_addr <= WIN_LAST));

  a_r5_enable_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    buf_en |-> (!pc_wr_n && xfer_grant && arm));

  a_r8_release_follows_arm: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(arm) |=> !rel);

  a_r8_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    rcnt <= CNT_W'(RECOV_COUNT));

  a_r8_count_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !rel |=> (rcnt == '0));
endmodule

bind xfer_wait_sync xs_checker #(
  .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_LAST(WIN_LAST), .RECOV_COUNT(RECOV_COUNT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pc_req(pc_req), .pc_addr(pc_addr), .pc_wr_n(pc_wr_n),
  .xfer_grant(xfer_grant), .pc_rdy(pc_rdy), .buf_en(buf_en),
  .arm(arm), .rel(rel), .rcnt(rcnt));

// File: tb/tb_xfer_wait_sync.sv
module tb_xfer_wait_sync;
  localparam int CLK_P  = 10;
  localparam int HALF_H = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pc_req = 1'b0;
  logic [19:0] pc_addr = '0;
  logic        pc_wr_n = 1'b1;
  logic        host_phi = 1'b0;
  logic        host_ba = 1'b0;
  logic        xfer_grant = 1'b0;
  logic        pc_rdy, buf_en;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int phcnt = 0;
  bit run_host = 0;

  always #(CLK_P/2) clk = ~clk;

  xfer_wait_sync dut (
    .clk(clk), .rst_n(rst_n), .pc_req(pc_req), .pc_addr(pc_addr), .pc_wr_n(pc_wr_n),
    .host_phi(host_phi), .host_ba(host_ba), .xfer_grant(xfer_grant),
    .pc_rdy(pc_rdy), .buf_en(buf_en));

  // behavioural reference: delay lines plus a small handshake state
  bit ph_line[$];
  bit ba_line[$];
  bit m_phi_prev, m_valid_prev, m_coin, m_arm, m_rel;
  int m_cnt;

  function automatic bit in_win();
    return pc_req && pc_addr >= 20'h0D000 && pc_addr <= 20'h0DFFF;
  endfunction

  function automatic bit m_valid();
    return ph_line[1] & ba_line[1];
  endfunction

  task automatic model_reset();
    ph_line = '{0, 0};
    ba_line = '{0, 0};
    m_phi_prev = 0; m_valid_prev = 0; m_coin = 0; m_arm = 0; m_rel = 0; m_cnt = 0;
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      bit v, w, rise, na, nr;
      int nc;
      v = m_valid();
      w = in_win();
      rise = ph_line[1] & !m_phi_prev;
      na = m_arm;
      if (m_arm && m_cnt == 2) na = 0;
      else if (w && v && !m_coin && !m_rel) na = 1;
      nr = m_rel;
      if (!m_arm) nr = 0;
      else if (m_valid_prev && !v) nr = 1;
      nc = m_cnt;
      if (!m_rel) nc = 0;
      else if (rise && m_cnt < 2) nc = m_cnt + 1;
      m_coin = w && v;
      m_arm = na; m_rel = nr; m_cnt = nc;
      m_valid_prev = v;
      m_phi_prev = ph_line[1];
      ph_line.push_front(host_phi); void'(ph_line.pop_back());
      ba_line.push_front(host_ba);  void'(ba_line.pop_back());
    end
  end

  task automatic check_bit(string tag, bit got, bit exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %b expected %b at cycle %0d", tag, got, exp, cyc);
    end
  endtask

  // per-clock comparison, a quarter period after the rising edge
  always @(posedge clk) begin
    cyc++;
    #(CLK_P/4);
    if (rst_n) begin
      check_bit("R2 R6 R7 R8 pc_rdy", pc_rdy, !(in_win() && !m_rel));
      check_bit("R4 R5 buf_en", buf_en,
                m_arm && m_valid() && !pc_wr_n && xfer_grant);
    end
  end

  always @(posedge clk) begin
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (run_host) begin
        phcnt++;
        if (phcnt == HALF_H) begin
          phcnt = 0;
          host_phi = ~host_phi;
        end
      end
    end
  endtask

  // wait for ready to rise, return whether the buffer opened on the way
  task automatic wait_release(output bit saw_en, output bit rose);
    saw_en = 0; rose = 0;
    for (int i = 0; i < 60 && !rose; i++) begin
      tick(1);
      #1;
      if (buf_en) saw_en = 1;
      if (pc_rdy) rose = 1;
    end
  endtask

  initial begin
    bit any_bad, saw, rose;
    tick(3);
    #1;
    check_bit("R1 reset pc_rdy", pc_rdy, 1'b1);
    check_bit("R1 reset buf_en", buf_en, 1'b0);
    rst_n = 1'b1;
    tick(6);
    #1;
    check_bit("R1 idle pc_rdy", pc_rdy, 1'b1);
    check_bit("R1 idle buf_en", buf_en, 1'b0);
    run_host = 1;

    // R3: out of window, both sides of it
    xfer_grant = 1; host_ba = 1; pc_wr_n = 0; pc_req = 1;
    any_bad = 0;
    for (int k = 0; k < 40; k++) begin
      pc_addr = (k < 20) ? 20'h0CFFF : 20'h0E000;
      tick(1); #1;
      if (!pc_rdy || buf_en) any_bad = 1;
    end
    check_bit("R3 outside window untouched", any_bad, 1'b0);
    pc_req = 0;
    tick(4);

    // R2 / R6: stall begins while bus unavailable
    host_ba = 0;
    tick(3);
    pc_addr = 20'h0D123; pc_wr_n = 0; pc_req = 1;
    #1;
    check_bit("R2 immediate stall", pc_rdy, 1'b0);
    any_bad = 0;
    for (int k = 0; k < 26; k++) begin
      tick(1); #1;
      if (pc_rdy || buf_en) any_bad = 1;
    end
    check_bit("R6 held across bus-unavailable periods", any_bad, 1'b0);
    host_ba = 1;
    wait_release(saw, rose);
    check_bit("R5 buffer opened during write", saw, 1'b1);
    check_bit("R7 released after valid phase", rose, 1'b1);
    pc_req = 0;
    tick(40);

    // R8: re-armed logic stalls the next access
    pc_addr = 20'h0DFFF; pc_req = 1;
    #1;
    check_bit("R8 stall again after recovery", pc_rdy, 1'b0);
    wait_release(saw, rose);
    check_bit("R8 second release", rose, 1'b1);
    pc_req = 0;
    tick(40);

    // R5: read cycle never opens the buffer
    pc_addr = 20'h0D000; pc_wr_n = 1; pc_req = 1;
    wait_release(saw, rose);
    check_bit("R5 read leaves buffer closed", saw, 1'b0);
    check_bit("R7 read released", rose, 1'b1);
    pc_req = 0;
    tick(40);

    // R5: write without grant never opens the buffer
    xfer_grant = 0; pc_wr_n = 0; pc_req = 1;
    wait_release(saw, rose);
    check_bit("R5 no grant leaves buffer closed", saw, 1'b0);
    pc_req = 0;
    tick(20);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule